// File: doc/BRIEF.md
# Cyclic Egress Gate Scheduler

This block opens and closes the eight per-class transmit gates of a single egress port according to a repeating gate control list. Software fills a small list in which each entry pairs an 8-bit gate mask with a duration in nanoseconds. It then writes a header that holds an absolute start time and the number of entries in use, and raises the enable. Time comes from an external, already synchronised nanosecond counter. The block does not keep its own clock.

Once enabled, the scheduler holds every gate open until the counter reaches the start time. It then makes entry 0 active and steps through the entries, wrapping around for as long as it stays enabled. Every gate change falls on a 200 ns slot grid that is phase-aligned to the start time. Each duration is rounded down to whole slots, and a duration below one slot still counts as one slot. The list and the header can be written only while the enable is low.

A four-state machine controls the sequence:
- ST_IDLE is the disabled state.
- ST_WAIT is enabled and waiting for the start time.
- ST_RUN is stepping through the list.
- ST_ERR is enabled with an unusable entry count.

The transitions are:
- ST_IDLE goes to ST_WAIT when the enable rises with a valid count.
- ST_IDLE goes to ST_ERR when the enable rises with an invalid count.
- ST_WAIT goes to ST_RUN when the time reaches the start time.
- Every state other than ST_IDLE returns to ST_IDLE when the enable drops.

Top module: `gate_sched`

## Requirements
- R1: While the enable is low, or while the block is enabled but the time is still below the start time, gate_open is 8'hFF, cur_entry is 0 and cycle_start is 0.
- R2: While the list runs, bit n of gate_open equals bit n of the mask of the active entry, for n = 0..7.
- R3: Entry 0 becomes active in the clock after the first sampled time at or above the start time. Entry k stays active for its slot count, and entries follow in increasing index order.
- R4: The slot count of an entry is its duration in ns divided by 200, rounded down, with a minimum of 1.
- R5: After entry count-1 the list wraps to entry 0, so one cycle lasts the sum of the slot counts. cur_entry is always below the count while running.
- R6: cycle_start is high for exactly the clocks in which entry 0 has just become active, both at the first start and at every wrap.
- R7: The active entry changes only when the time passes a slot boundary (start + k*200 ns), and by at most one entry per clock.
- R8: List and header writes are ignored while the enable is high.
- R9: A count of 0, or a count above 16, raises cfg_err while enabled and keeps gate_open at 8'hFF. cfg_err clears once the enable drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sched_en | input | 1 | Scheduler enable |
| ent_we | input | 1 | List entry write strobe |
| ent_addr | input | 4 | Entry index to write |
| ent_mask | input | 8 | Gate mask, bit n opens class n |
| ent_ivl_ns | input | 32 | Entry duration in ns |
| hdr_we | input | 1 | Header write strobe |
| hdr_base_ns | input | 64 | Absolute start time in ns |
| hdr_count | input | 5 | Number of entries in use (1..16) |
| ptp_time_ns | input | 64 | Synchronised time in ns |
| gate_open | output | 8 | Per-class gate enables |
| cur_entry | output | 4 | Active entry index |
| cycle_start | output | 1 | Pulse when entry 0 becomes active |
| cfg_err | output | 1 | Invalid entry count |

## Verification
The bench feeds time in steps of 50, 130 and 200 ns and uses a start time that is not aligned to the step. A design that advanced on every clock, or that aligned its slots to absolute time rather than to the start time, would switch entries at the wrong sample. Durations of 199 and 450 ns exercise the rounding and the one-slot floor; a wrong divider would stretch or collapse an entry. A single-entry, single-slot list must pulse cycle_start on every slot, which exposes a design that pulses only on the first start. Writes issued while running, and counts of 0 and 17, target designs that would accept a live list edit or run an empty list.

// File: rtl/gs_pkg.sv
package gs_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_RUN  = 2'd2,
        ST_ERR  = 2'd3
    } gs_state_e;

    localparam int unsigned GS_SLOT_NS = 200;
endpackage

// File: rtl/gs_list.sv
module gs_list #(
    parameter int NUM_TC = 8,
    parameter int DEPTH  = 16,
    parameter int IVL_W  = 32,
    parameter int IDX_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_addr,
    input  logic [NUM_TC-1:0] wr_mask,
    input  logic [IVL_W-1:0]  wr_ivl_ns,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic [IDX_W-1:0]  rd_nidx,
    output logic [NUM_TC-1:0] rd_mask,
    output logic [IVL_W-1:0]  nxt_slots
);
    import gs_pkg::*;

    logic [NUM_TC-1:0] mask_q  [DEPTH];
    logic [IVL_W-1:0]  slots_q [DEPTH];
    logic [IVL_W-1:0]  wr_slots;

    // Duration to slot count, rounded down, never below one slot.
    always_comb begin
        wr_slots = wr_ivl_ns / IVL_W'(GS_SLOT_NS);
        if (wr_slots == '0) begin
            wr_slots = IVL_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int e = 0; e < DEPTH; e++) begin
                mask_q[e]  <= '1;
                slots_q[e] <= IVL_W'(1);
            end
        end else if (wr_en) begin
            for (int e = 0; e < DEPTH; e++) begin
                if (wr_addr == IDX_W'(e)) begin
                    mask_q[e]  <= wr_mask;
                    slots_q[e] <= wr_slots;
                end
            end
        end
    end

    assign rd_mask   = mask_q[rd_idx];
    assign nxt_slots = slots_q[rd_nidx];
endmodule

// File: rtl/gs_slot_timer.sv
module gs_slot_timer #(
    parameter int TIME_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              run,
    input  logic [TIME_W-1:0] base_ns,
    input  logic [TIME_W-1:0] time_ns,
    output logic              tick
);
    import gs_pkg::*;

    logic [TIME_W-1:0] next_q;

    // One boundary per clock at most; a large time jump is caught up slot by slot.
    assign tick = run && (time_ns >= next_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            next_q <= '0;
        end else if (load) begin
            next_q <= base_ns + TIME_W'(GS_SLOT_NS);
        end else if (tick) begin
            next_q <= next_q + TIME_W'(GS_SLOT_NS);
        end
    end
endmodule

// File: rtl/gate_sched.sv
module gate_sched #(
    parameter int NUM_TC = 8,
    parameter int DEPTH  = 16,
    parameter int TIME_W = 64,
    parameter int IVL_W  = 32,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sched_en,
    input  logic              ent_we,
    input  logic [IDX_W-1:0]  ent_addr,
    input  logic [NUM_TC-1:0] ent_mask,
    input  logic [IVL_W-1:0]  ent_ivl_ns,
    input  logic              hdr_we,
    input  logic [TIME_W-1:0] hdr_base_ns,
    input  logic [CNT_W-1:0]  hdr_count,
    input  logic [TIME_W-1:0] ptp_time_ns,
    output logic [NUM_TC-1:0] gate_open,
    output logic [IDX_W-1:0]  cur_entry,
    output logic              cycle_start,
    output logic              cfg_err
);
    import gs_pkg::*;

    gs_state_e         state_q, state_d;
    logic [TIME_W-1:0] base_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [IDX_W-1:0]  idx_q, nidx;
    logic [IVL_W-1:0]  remain_q, nxt_slots;
    logic [NUM_TC-1:0] act_mask;
    logic              cs_q, start, tick, cnt_ok, running;

    assign cnt_ok  = (cnt_q != '0) && (cnt_q <= CNT_W'(DEPTH));
    assign start   = (state_q == ST_WAIT) && sched_en && (ptp_time_ns >= base_q);
    assign running = (state_q == ST_RUN);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
            cnt_q  <= '0;
        end else if (hdr_we && !sched_en) begin
            base_q <= hdr_base_ns;
            cnt_q  <= hdr_count;
        end
    end

    gs_list #(.NUM_TC(NUM_TC), .DEPTH(DEPTH), .IVL_W(IVL_W), .IDX_W(IDX_W)) u_list (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (ent_we && !sched_en),
        .wr_addr   (ent_addr),
        .wr_mask   (ent_mask),
        .wr_ivl_ns (ent_ivl_ns),
        .rd_idx    (idx_q),
        .rd_nidx   (nidx),
        .rd_mask   (act_mask),
        .nxt_slots (nxt_slots)
    );

    gs_slot_timer #(.TIME_W(TIME_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (start),
        .run     (running && sched_en),
        .base_ns (base_q),
        .time_ns (ptp_time_ns),
        .tick    (tick)
    );

    // Next entry: 0 when starting or wrapping, otherwise idx+1.
    always_comb begin
        nidx = '0;
        if (running && ((CNT_W'(idx_q) + CNT_W'(1)) < cnt_q)) begin
            nidx = idx_q + IDX_W'(1);
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (sched_en) state_d = cnt_ok ? ST_WAIT : ST_ERR;
            ST_WAIT: if (!sched_en) state_d = ST_IDLE;
                     else if (start) state_d = ST_RUN;
            ST_RUN:  if (!sched_en) state_d = ST_IDLE;
            ST_ERR:  if (!sched_en) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Entry sequencer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q    <= '0;
            remain_q <= '0;
            cs_q     <= 1'b0;
        end else if (!sched_en || (!running && !start)) begin
            idx_q    <= '0;
            remain_q <= '0;
            cs_q     <= 1'b0;
        end else if (start) begin
            idx_q    <= '0;
            remain_q <= nxt_slots;
            cs_q     <= 1'b1;
        end else if (tick) begin
            if (remain_q <= IVL_W'(1)) begin
                idx_q    <= nidx;
                remain_q <= nxt_slots;
                cs_q     <= (nidx == '0);
            end else begin
                remain_q <= remain_q - IVL_W'(1);
                cs_q     <= 1'b0;
            end
        end else begin
            cs_q <= 1'b0;
        end
    end

    // Outputs
    always_comb begin
        gate_open   = '1;
        cfg_err     = 1'b0;
        unique case (state_q)
            ST_RUN:  gate_open = act_mask;
            ST_ERR:  cfg_err   = 1'b1;
            default: gate_open = '1;
        endcase
        cur_entry   = idx_q;
        cycle_start = cs_q;
    end
endmodule

// File: rtl/gs_chk.sv
module gs_chk #(
    parameter int NUM_TC = 8,
    parameter int IDX_W  = 4,
    parameter int CNT_W  = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sched_en,
    input logic              running,
    input logic [CNT_W-1:0]  cnt_q,
    input logic [NUM_TC-1:0] gate_open,
    input logic [IDX_W-1:0]  cur_entry,
    input logic              cycle_start,
    input logic              cfg_err
);
    AST_IDLE_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        !sched_en |=> (gate_open == '1 && cur_entry == '0 && !cycle_start)); // R1

    AST_ERR_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> (gate_open == '1 && !running)); // R9

    AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        running |-> (CNT_W'(cur_entry) < cnt_q)); // R5

    AST_CS_ENTRY0: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_start |-> (cur_entry == '0 && running)); // R6

    AST_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (running && $past(running) && cur_entry != $past(cur_entry))
        |-> (cur_entry == '0 || cur_entry == $past(cur_entry) + IDX_W'(1))); // R7
endmodule

bind gate_sched gs_chk #(.NUM_TC(NUM_TC), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sched_en    (sched_en),
    .running     (running),
    .cnt_q       (cnt_q),
    .gate_open   (gate_open),
    .cur_entry   (cur_entry),
    .cycle_start (cycle_start),
    .cfg_err     (cfg_err)
);

// File: tb/gate_sched_test.sv
`timescale 1ns/1ps
module gate_sched_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sched_en = 1'b0;
    logic        ent_we = 1'b0;
    logic [3:0]  ent_addr = '0;
    logic [7:0]  ent_mask = '0;
    logic [31:0] ent_ivl_ns = '0;
    logic        hdr_we = 1'b0;
    logic [63:0] hdr_base_ns = '0;
    logic [4:0]  hdr_count = '0;
    logic [63:0] ptp_time_ns = '0;
    logic [7:0]  gate_open;
    logic [3:0]  cur_entry;
    logic        cycle_start;
    logic        cfg_err;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    gate_sched uut (
        .clk(clk), .rst_n(rst_n), .sched_en(sched_en),
        .ent_we(ent_we), .ent_addr(ent_addr), .ent_mask(ent_mask), .ent_ivl_ns(ent_ivl_ns),
        .hdr_we(hdr_we), .hdr_base_ns(hdr_base_ns), .hdr_count(hdr_count),
        .ptp_time_ns(ptp_time_ns), .gate_open(gate_open), .cur_entry(cur_entry),
        .cycle_start(cycle_start), .cfg_err(cfg_err)
    );

    typedef struct packed {
        int unsigned      cnt;
        int unsigned      step;
        longint unsigned  base;
        int unsigned      run;
        logic [3:0][7:0]  masks;
        logic [3:0][31:0] ivls;
    } vec_t;

    // Schedules: {count, time step, start time, samples, masks[3:0], durations[3:0]}
    localparam vec_t VECS [4] = '{
        // two-entry list: class 7 for 100 us, classes 0..6 for 400 us (R3, R5)
        '{cnt: 2, step: 200, base: 1000, run: 5600,
          masks: {8'h00, 8'h00, 8'h7F, 8'h80}, ivls: {32'd0, 32'd0, 32'd400000, 32'd100000}},
        // unaligned start, 450 ns -> 2 slots, 199 ns -> 1 slot (R4, R7)
        '{cnt: 3, step: 50, base: 3010, run: 400,
          masks: {8'h00, 8'h04, 8'h02, 8'h01}, ivls: {32'd0, 32'd199, 32'd450, 32'd600}},
        // four entries including an all-closed one, 250 ns -> 1 slot (R2, R4)
        '{cnt: 4, step: 130, base: 500, run: 300,
          masks: {8'hFF, 8'h00, 8'hF0, 8'h0F}, ivls: {32'd250, 32'd1000, 32'd400, 32'd200}},
        // single entry of one slot: wraps every slot (R5, R6)
        '{cnt: 1, step: 200, base: 400, run: 50,
          masks: {8'h00, 8'h00, 8'h00, 8'h55}, ivls: {32'd0, 32'd0, 32'd0, 32'd200}}
    };

    // Bench-side model of the schedule
    logic [7:0]  m_mask  [16];
    longint      m_slots [16];
    int          m_cnt;
    longint      m_base;
    longint      prev_slot;

    task automatic chk(bit ok, string req, string what, longint act, longint exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wr_ent(int a, logic [7:0] m, logic [31:0] iv);
        @(negedge clk);
        ent_we = 1'b1; ent_addr = 4'(a); ent_mask = m; ent_ivl_ns = iv;
        @(negedge clk);
        ent_we = 1'b0;
    endtask

    task automatic wr_hdr(longint b, int c);
        @(negedge clk);
        hdr_we = 1'b1; hdr_base_ns = 64'(b); hdr_count = 5'(c);
        @(negedge clk);
        hdr_we = 1'b0;
    endtask

    // Drive one time value, sample after the edge and compare with the model.
    task automatic sample(longint t);
        longint slot, pos, total, acc;
        int e;
        logic [7:0] eg;
        logic [3:0] ei;
        bit ecs;
        @(negedge clk);
        ptp_time_ns = 64'(t);
        @(posedge clk);
        #1;
        if (t < m_base) begin
            chk(gate_open == 8'hFF, "R1", "pre-start gates", gate_open, 8'hFF);
            chk(cur_entry == 0 && !cycle_start, "R1", "pre-start idx/cs",
                {cur_entry, cycle_start}, 0);
        end else begin
            total = 0;
            for (int k = 0; k < m_cnt; k++) total += m_slots[k];
            slot = (t - m_base) / 200;
            pos  = slot % total;
            acc = 0; e = 0;
            for (int k = 0; k < m_cnt; k++) begin
                if (pos >= acc && pos < acc + m_slots[k]) e = k;
                acc += m_slots[k];
            end
            eg  = m_mask[e];
            ei  = 4'(e);
            ecs = (slot != prev_slot) && (pos == 0);
            prev_slot = slot;
            chk(gate_open == eg, "R2", "gate mask", gate_open, eg);
            chk(cur_entry == ei, "R3/R7", "active entry", cur_entry, ei);
            chk(cycle_start == ecs, "R6", "cycle_start", cycle_start, ecs);
        end
    endtask

    task automatic load_model(vec_t v);
        m_cnt = int'(v.cnt);
        m_base = longint'(v.base);
        prev_slot = -1;
        for (int k = 0; k < 4; k++) begin
            m_mask[k]  = v.masks[k];
            m_slots[k] = longint'(v.ivls[k]) / 200;      // R4: floor, minimum one slot
            if (m_slots[k] == 0) m_slots[k] = 1;
        end
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk(gate_open == 8'hFF, "R1", "reset gates", gate_open, 8'hFF);
        chk(cur_entry == 0, "R1", "reset entry", cur_entry, 0);
        chk(!cycle_start && !cfg_err, "R1", "reset pulses", {cycle_start, cfg_err}, 0);
        @(negedge clk);
        rst_n = 1'b1;

        // Vector table walk
        foreach (VECS[i]) begin
            longint t;
            sched_en = 1'b0;
            for (int k = 0; k < int'(VECS[i].cnt); k++)
                wr_ent(k, VECS[i].masks[k], VECS[i].ivls[k]);
            wr_hdr(longint'(VECS[i].base), int'(VECS[i].cnt));
            load_model(VECS[i]);
            @(negedge clk);
            ptp_time_ns = '0;
            sched_en = 1'b1;
            t = 0;
            while (t < m_base) begin
                sample(t);
                t += longint'(VECS[i].step);
            end
            for (int s = 0; s < int'(VECS[i].run); s++) begin
                sample(t);
                t += longint'(VECS[i].step);
            end
            @(negedge clk);
            sched_en = 1'b0;
            @(posedge clk); #1;
            chk(gate_open == 8'hFF && cur_entry == 0, "R1", "after disable",
                {gate_open, cur_entry}, 12'hFF0);
        end

        // R8: writes while running are ignored
        begin
            longint t;
            load_model(VECS[3]);
            wr_ent(0, 8'h55, 32'd200);
            wr_hdr(400, 1);
            @(negedge clk);
            ptp_time_ns = '0;
            sched_en = 1'b1;
            t = 0;
            for (int s = 0; s < 6; s++) begin sample(t); t += 200; end
            @(negedge clk);
            ent_we = 1'b1; ent_addr = 4'd0; ent_mask = 8'hAA; ent_ivl_ns = 32'd5000;
            hdr_we = 1'b1; hdr_base_ns = 64'd0; hdr_count = 5'd0;
            for (int s = 0; s < 4; s++) begin sample(t); t += 200; end
            ent_we = 1'b0; hdr_we = 1'b0;
            for (int s = 0; s < 4; s++) begin
                sample(t);
                chk(gate_open == 8'h55, "R8", "mask after live write", gate_open, 8'h55);
                chk(!cfg_err, "R8", "count after live write", cfg_err, 0);
                t += 200;
            end
            @(negedge clk);
            sched_en = 1'b0;
        end

        // R9: zero and oversize counts
        wr_hdr(400, 0);
        @(negedge clk);
        sched_en = 1'b1;
        ptp_time_ns = 64'd1000;
        repeat (2) @(posedge clk);
        #1;
        chk(cfg_err == 1'b1, "R9", "count 0 error", cfg_err, 1);
        chk(gate_open == 8'hFF, "R9", "count 0 gates", gate_open, 8'hFF);
        @(negedge clk);
        sched_en = 1'b0;
        @(posedge clk); #1;
        chk(cfg_err == 1'b0, "R9", "error clears", cfg_err, 0);
        wr_hdr(400, 17);
        @(negedge clk);
        sched_en = 1'b1;
        repeat (2) @(posedge clk);
        #1;
        chk(cfg_err == 1'b1, "R9", "count 17 error", cfg_err, 1);
        chk(gate_open == 8'hFF, "R9", "count 17 gates", gate_open, 8'hFF);
        @(negedge clk);
        sched_en = 1'b0;
        @(posedge clk); #1;

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule